// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two bidirectional data buses, side A and side B. Each side has a storage register. Each direction of transfer has a source select that picks one of two values for the driven side: the live data on the opposite bus, or the value held in that direction's register. One side can drive at a time. When the shared enable is inactive, neither side drives and both sides act only as inputs.

Each bus pin group is split into an input vector, an output vector and a drive enable, so the pad ring or a bus fabric does the tristate resolution. A capture strobe is given for each register. The block samples each strobe on the system clock. The first clock edge that sees a strobe high loads the matching register from the resolved value of its bus. The resolved value is the external input when the block does not drive that side, or the block's own output when it does. Captures do not depend on the enable, direction or source selects, so either bus can be recorded at any time. All drive logic is combinational and adds no latency.

Top module: `xcv_reg_transceiver`

## Requirements
- R1: While `out_en_n` is 1, both `a_oe` and `b_oe` are 0.
- R2: While `out_en_n` is 0, `dir_to_b` = 1 sets `b_oe` = 1 and `a_oe` = 0, and `dir_to_b` = 0 sets `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R3: While B is driven, `b_out` equals `a_in` if `src_ab_reg` = 0.
- R4: While A is driven, `a_out` equals `b_in` if `src_ba_reg` = 0, and equals the B register if `src_ba_reg` = 1.
- R5: On the first clock edge where `cap_ab` is seen high after being low, the A register loads the resolved A value. While B is driven with `src_ab_reg` = 1, `b_out` shows the new value in the cycle right after that edge. Holding the strobe high does not cause another load. `cap_ba` does the same for the B register.
- R6: Captures take place in every control state, including when `out_en_n` = 1 and neither side is driven.
- R7: Without a rising strobe, a register keeps its value, whatever data passes through on the live path.
- R8: Capturing the side that the block is driving stores the value being driven.
- R9: The asynchronous reset `rst_n` clears both registers to 0.
- R10: The output data of a side that is not driven is 0.
- R11: A change on a data input reaches the driven output in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_en_n | input | 1 | Active-low enable for port driving |
| dir_to_b | input | 1 | 1: B is driven from the A side; 0: A is driven from the B side |
| src_ab_reg | input | 1 | B output source: 0 live A data, 1 A register |
| src_ba_reg | input | 1 | A output source: 0 live B data, 1 B register |
| cap_ab | input | 1 | Capture strobe for the A register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B register (rising edge) |
| a_in | input | W | Data seen on bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Data seen on bus B |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench steps through all sixteen combinations of enable, direction and both source selects, and issues strobes on both capture inputs in each one. A design that gated the strobes with the enable or direction would lose the data captured while the buses are idle, which shows up later as a stale register value when that register is displayed. A capture of the side the block is driving checks that the register stores the driven value and not the external input; a design that picked the wrong one would store the far bus's pin data. The bench also holds a strobe high across a data change to catch level-sensitive loading, and changes live data in mid-cycle to catch any latency added on the pass-through path.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
  // side indices used for the per-side capture structure
  localparam int unsigned SIDE_A   = 0;
  localparam int unsigned SIDE_B   = 1;
  localparam int unsigned NUM_SIDE = 2;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } xcv_drive_t;

  function automatic xcv_drive_t xcv_decode_drive(input logic en_n, input logic to_b);
    xcv_drive_t d;
    d.drive_a = ~en_n & ~to_b;
    d.drive_b = ~en_n &  to_b;
    return d;
  endfunction
endpackage

// File: rtl/xcv_rst_sync.sv
module xcv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/xcv_edge_det.sv
module xcv_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic strobe_q,
  output logic rise
);
  logic last_q;
  logic last_d;

  always_comb begin
    last_d = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  assign strobe_q = last_q;
  assign rise     = strobe & ~last_q;
endmodule

// File: rtl/xcv_store_reg.sv
module xcv_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/xcv_port_route.sv
module xcv_port_route
  import xcv_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         out_en_n,
  input  logic         dir_to_b,
  input  logic         src_ab_reg,
  input  logic         src_ba_reg,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] qa,
  input  logic [W-1:0] qb,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_res,
  output logic [W-1:0] b_res
);
  xcv_drive_t drv;
  logic [W-1:0] to_a;
  logic [W-1:0] to_b;

  always_comb begin
    drv = xcv_decode_drive(out_en_n, dir_to_b);
    // only one side is ever driven, so each candidate uses the far side's raw input
    to_a = src_ba_reg ? qb : b_in;
    to_b = src_ab_reg ? qa : a_in;
    a_res = drv.drive_a ? to_a : a_in;
    b_res = drv.drive_b ? to_b : b_in;
    a_out = drv.drive_a ? to_a : '0;
    b_out = drv.drive_b ? to_b : '0;
    a_oe  = drv.drive_a;
    b_oe  = drv.drive_b;
  end
endmodule

// File: rtl/xcv_reg_transceiver.sv
module xcv_reg_transceiver
  import xcv_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_en_n,
  input  logic         dir_to_b,
  input  logic         src_ab_reg,
  input  logic         src_ba_reg,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic                rst_n_sync;
  logic [NUM_SIDE-1:0] strobe_v;
  logic [NUM_SIDE-1:0] strobe_q_v;
  logic [NUM_SIDE-1:0] rise_v;
  logic [W-1:0]        res_v [NUM_SIDE];
  logic [W-1:0]        q_v   [NUM_SIDE];
  logic [W-1:0]        a_res;
  logic [W-1:0]        b_res;

  xcv_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign strobe_v[SIDE_A] = cap_ab;
  assign strobe_v[SIDE_B] = cap_ba;
  assign res_v[SIDE_A]    = a_res;
  assign res_v[SIDE_B]    = b_res;

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    xcv_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .strobe   (strobe_v[s]),
      .strobe_q (strobe_q_v[s]),
      .rise     (rise_v[s])
    );
    xcv_store_reg #(.W(W)) u_store (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .load  (rise_v[s]),
      .d     (res_v[s]),
      .q     (q_v[s])
    );
  end

  xcv_port_route #(.W(W)) u_route (
    .out_en_n   (out_en_n),
    .dir_to_b   (dir_to_b),
    .src_ab_reg (src_ab_reg),
    .src_ba_reg (src_ba_reg),
    .a_in       (a_in),
    .b_in       (b_in),
    .qa         (q_v[SIDE_A]),
    .qb         (q_v[SIDE_B]),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .a_res      (a_res),
    .b_res      (b_res)
  );
endmodule

// File: rtl/xcv_reg_transceiver_chk.sv
module xcv_reg_transceiver_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_ns,
  input logic         out_en_n,
  input logic         dir_to_b,
  input logic         src_ab_reg,
  input logic         src_ba_reg,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         cap_ab_q,
  input logic         cap_ba_q,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] qa,
  input logic [W-1:0] qb
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ns)
    out_en_n |-> (!a_oe && !b_oe)); // R1
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_ns)
    !(a_oe && b_oe)); // R2
  AST_DIR_B: assert property (@(posedge clk) disable iff (!rst_ns)
    (!out_en_n && dir_to_b) |-> b_oe); // R2
  AST_LIVE_B: assert property (@(posedge clk) disable iff (!rst_ns)
    (b_oe && !src_ab_reg) |-> (b_out == a_in)); // R3
  AST_LIVE_A: assert property (@(posedge clk) disable iff (!rst_ns)
    (a_oe && !src_ba_reg) |-> (a_out == b_in)); // R4
  AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_ns)
    !a_oe |-> (a_out == '0)); // R10
  AST_CAP_A: assert property (@(posedge clk) disable iff (!rst_ns)
    (cap_ab && !cap_ab_q) |=> (qa == $past(a_oe ? a_out : a_in))); // R5
  AST_CAP_B: assert property (@(posedge clk) disable iff (!rst_ns)
    (cap_ba && !cap_ba_q) |=> (qb == $past(b_oe ? b_out : b_in))); // R8
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_ns)
    !(cap_ab && !cap_ab_q) |=> $stable(qa)); // R7
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_ns)
    !(cap_ba && !cap_ba_q) |=> $stable(qb)); // R7
endmodule

bind xcv_reg_transceiver xcv_reg_transceiver_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_ns     (rst_n_sync),
  .out_en_n   (out_en_n),
  .dir_to_b   (dir_to_b),
  .src_ab_reg (src_ab_reg),
  .src_ba_reg (src_ba_reg),
  .cap_ab     (cap_ab),
  .cap_ba     (cap_ba),
  .cap_ab_q   (strobe_q_v[0]),
  .cap_ba_q   (strobe_q_v[1]),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .qa         (q_v[0]),
  .qb         (q_v[1])
);

// File: tb/xcv_reg_transceiver_tb_top.sv
`timescale 1ns/1ps
module xcv_reg_transceiver_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic out_en_n, dir_to_b, src_ab_reg, src_ba_reg, cap_ab, cap_ba;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad = 0;
  bit model_on = 0;
  bit done = 0;
  logic [W-1:0] m_qa, m_qb;
  logic m_pab, m_pba;

  always #5 clk = ~clk;

  xcv_reg_transceiver #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
    .src_ab_reg(src_ab_reg), .src_ba_reg(src_ba_reg), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // behavioural reference of the capture registers
  always @(posedge clk) begin
    if (model_on) begin
      logic [W-1:0] ra, rb;
      ra = (!out_en_n && !dir_to_b) ? (src_ba_reg ? m_qb : b_in) : a_in;
      rb = (!out_en_n &&  dir_to_b) ? (src_ab_reg ? m_qa : a_in) : b_in;
      if (cap_ab && !m_pab) m_qa <= ra;
      if (cap_ba && !m_pba) m_qb <= rb;
      m_pab <= cap_ab;
      m_pba <= cap_ba;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      logic ea, eb;
      logic [W-1:0] xa, xb;
      ea = !out_en_n && !dir_to_b;
      eb = !out_en_n &&  dir_to_b;
      xa = ea ? (src_ba_reg ? m_qb : b_in) : '0;
      xb = eb ? (src_ab_reg ? m_qa : a_in) : '0;
      check(out_en_n ? "R1 a_oe" : "R2 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ea});
      check(out_en_n ? "R1 b_oe" : "R2 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eb});
      check(!ea ? "R10 a_out" : (src_ba_reg ? "R4 a_out reg" : "R4 a_out live"), a_out, xa);
      check(!eb ? "R10 b_out" : (src_ab_reg ? "R5 b_out reg" : "R3 b_out live"), b_out, xb);
    end
  end

  task automatic cyc(input logic en_n, input logic tb, input logic sab, input logic sba,
                     input logic [W-1:0] ai, input logic [W-1:0] bi,
                     input logic cab, input logic cba);
    @(posedge clk); #2;
    out_en_n = en_n; dir_to_b = tb; src_ab_reg = sab; src_ba_reg = sba;
    a_in = ai; b_in = bi; cap_ab = cab; cap_ba = cba;
  endtask

  task automatic at_sample;
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    out_en_n = 1'b1; dir_to_b = 1'b0; src_ab_reg = 1'b0; src_ba_reg = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = '0; b_in = '0;
    m_qa = '0; m_qb = '0; m_pab = 1'b0; m_pba = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    model_on = 1;

    // R9: registers read back as zero after reset
    cyc(0, 1, 1, 0, 8'hAA, 8'h55, 0, 0); at_sample;
    check("R9 A register", b_out, 8'h00);
    cyc(0, 0, 0, 1, 8'hAA, 8'h55, 0, 0); at_sample;
    check("R9 B register", a_out, 8'h00);

    // R6: capture while no side is driven
    cyc(1, 0, 0, 0, 8'hC3, 8'h3C, 1, 1);
    cyc(0, 1, 1, 0, 8'h00, 8'h00, 0, 0); at_sample;
    check("R6 A captured idle", b_out, 8'hC3);
    cyc(0, 0, 0, 1, 8'h00, 8'h00, 0, 0); at_sample;
    check("R6 B captured idle", a_out, 8'h3C);

    // R7: live traffic without strobes leaves registers alone
    cyc(0, 1, 0, 0, 8'h11, 8'h22, 0, 0);
    cyc(0, 0, 0, 0, 8'h33, 8'h44, 0, 0);
    cyc(0, 1, 1, 0, 8'h55, 8'h66, 0, 0); at_sample;
    check("R7 A register kept", b_out, 8'hC3);

    // R5: a held strobe loads only once
    cyc(1, 0, 0, 0, 8'h12, 8'h00, 1, 0);
    cyc(1, 0, 0, 0, 8'h34, 8'h00, 1, 0);
    cyc(0, 1, 1, 0, 8'h56, 8'h00, 0, 0); at_sample;
    check("R5 single load on held strobe", b_out, 8'h12);

    // R5: shown value updates the cycle after the capture edge
    cyc(0, 1, 1, 0, 8'h9E, 8'h00, 1, 0); at_sample;
    check("R5 before edge", b_out, 8'h12);
    cyc(0, 1, 1, 0, 8'h00, 8'h00, 0, 0); at_sample;
    check("R5 after edge", b_out, 8'h9E);

    // R8: capturing the driven side stores the driven value
    cyc(0, 0, 0, 0, 8'hFF, 8'h5A, 1, 0);
    cyc(0, 1, 1, 0, 8'h00, 8'h00, 0, 0); at_sample;
    check("R8 driven A stored", b_out, 8'h5A);
    cyc(0, 1, 0, 0, 8'h77, 8'hEE, 0, 1);
    cyc(0, 0, 0, 1, 8'h00, 8'h00, 0, 0); at_sample;
    check("R8 driven B stored", a_out, 8'h77);

    // R11: live change seen in the same cycle
    cyc(0, 1, 0, 0, 8'h3C, 8'h00, 0, 0); at_sample;
    check("R11 same-cycle pass", b_out, 8'h3C);
    cyc(0, 0, 0, 0, 8'h00, 8'hA7, 0, 0); at_sample;
    check("R11 same-cycle pass back", a_out, 8'hA7);

    // every control combination with strobes on both sides
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 6; r++) begin
        cyc(c[3], c[2], c[1], c[0], W'($urandom), W'($urandom),
            (r % 2) == 0, (r % 3) == 0);
      end
    end
    cyc(0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
    cyc(0, 0, 0, 1, 8'h00, 8'h00, 0, 0);
    at_sample;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule